// File: doc/BRIEF.md
# Endian-Aware Splitter for a 16-Bit External Data Bus

This block turns one CPU-side access of one, two or four bytes into the series of external cycles that a 16-bit data bus needs. The bus has an upper byte lane (bits 15..8) and a lower byte lane (bits 7..0). Each bus cycle moves either a single byte on one lane or a full 16-bit word on both lanes. A misaligned word, or a longword, is broken into several such cycles. The cycle address steps forward from the request address.

A runtime endian input sets two things: which lane carries a byte at an even or an odd address, and which end of a multi-byte datum sits at the lowest address. For writes, the block places the datum's bytes on the proper lanes of each cycle. For reads, it collects the returned lanes into a 32-bit result. It then reports completion with a one-cycle done pulse.

Each external cycle waits for a ready input. A new request is taken only while the block is idle.

Top module: `bus16_splitter`

## Requirements
- R1: With `req_big_endian`=1, a byte access (size code 0) takes one bus cycle at the request address. An even address uses only the upper lane and an odd address uses only the lower lane.
- R2: With `req_big_endian`=0, a byte access takes one bus cycle. An even address uses only the lower lane and an odd address uses only the upper lane.
- R3: A word access (size code 1) at an even address takes one bus cycle at that address, with both lanes enabled.
- R4: A word access at an odd address A takes two single-byte cycles, at A and then at A+1.
- R5: A longword access (size code 2) at an even address A takes two full-word cycles, at A and then at A+2.
- R6: A longword access at an odd address A takes three cycles: a byte at A, then a word at A+1, then a byte at A+3.
- R7: Byte order follows the endian input. Big-endian puts the most significant byte of the datum at the lowest address, and little-endian puts the least significant byte there. On a write, each byte of `req_wdata` appears on the lane that serves its address.
- R8: A read gathers the lanes of every cycle into `rd_data`, with bits above the access size reading zero. `done` is high for exactly one clock, in the cycle after the last bus cycle sees `bus_ready`.
- R9: A lane enable is high only for a lane that carries a datum byte in that cycle. `bus_rd` is high only during read cycles and `bus_wr` only during write cycles. None of these is high while `bus_cyc` is low.
- R10: While `bus_ready` is low, the current cycle's address, lane enables and write data hold steady, and the sequence does not advance.
- R11: `req_ready` is high only when no access is in progress. A `req_valid` raised while busy is ignored.
- R12: After reset, the block is idle: `req_ready`=1, `bus_cyc`=0, `done`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle; a valid request is taken at this edge |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 word, 2 longword |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write datum, right-aligned |
| req_big_endian | input | 1 | 1 big-endian, 0 little-endian |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 32 | Assembled read result, valid with done |
| bus_cyc | output | 1 | A bus cycle is in progress |
| bus_addr | output | ADDR_W | Address of the current bus cycle |
| bus_hi_en | output | 1 | Upper lane (15..8) enable |
| bus_lo_en | output | 1 | Lower lane (7..0) enable |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 16 | Lane write data |
| bus_rdata | input | 16 | Lane read data |
| bus_ready | input | 1 | Current bus cycle completes at this edge |

## Verification
The completion of one access and the acceptance of the next fall in the same clock. The block goes idle in its done cycle, and a request already waiting is taken on that edge. The bench provokes this by presenting every next request in the very cycle that done appears. It then judges both the completed access (its result or its stored bytes) and the new access (its cycle count, addresses and lanes) against values computed from the address, size and endian rules. The sweep covers every size, every address alignment, both endians and both directions, under a rotating pattern of wait cycles.

// File: rtl/bus16_pkg.sv
// Shared types and sizes for the 16-bit bus splitter.
package bus16_pkg;
    localparam int LANE_W      = 8;
    localparam int BUS_BYTES   = 2;
    localparam int DATUM_BYTES = 4;
    localparam int BUS_W       = LANE_W * BUS_BYTES;
    localparam int DATUM_W     = LANE_W * DATUM_BYTES;
    localparam int IDX_W       = $clog2(DATUM_BYTES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } acc_size_e;

    // One bus cycle: the datum byte offset of its first byte, and whether it is a word.
    typedef struct packed {
        logic [IDX_W-1:0] offs;
        logic             two;
    } beat_t;
endpackage

// File: rtl/bus16_cycle_plan.sv
// Cycle planner: for a given access size, address alignment and beat number,
// gives the byte offset and width of that bus cycle and flags the final beat.
// Assumes the beat number never passes the final beat for the size.
module bus16_cycle_plan
    import bus16_pkg::*;
(
    input  acc_size_e          size,
    input  logic               odd,
    input  logic [IDX_W-1:0]   beat,
    output beat_t              plan,
    output logic               last
);
    logic [IDX_W-1:0] final_beat;

    // Number of the last beat for this size and alignment.
    always_comb begin
        case (size)
            SZ_BYTE: final_beat = '0;
            SZ_WORD: final_beat = IDX_W'(odd);
            default: final_beat = odd ? IDX_W'(2) : IDX_W'(1);
        endcase
    end

    // Byte offset and width of the current beat.
    always_comb begin
        plan = '{offs: '0, two: 1'b0};
        case (size)
            SZ_BYTE: plan = '{offs: '0, two: 1'b0};
            SZ_WORD: begin
                if (!odd) plan = '{offs: '0, two: 1'b1};
                else      plan = '{offs: IDX_W'(beat[0]), two: 1'b0};
            end
            default: begin
                if (!odd) begin
                    plan = '{offs: {beat[0], 1'b0}, two: 1'b1};
                end else begin
                    case (beat)
                        IDX_W'(0): plan = '{offs: IDX_W'(0), two: 1'b0};
                        IDX_W'(1): plan = '{offs: IDX_W'(1), two: 1'b1};
                        default:   plan = '{offs: IDX_W'(3), two: 1'b0};
                    endcase
                end
            end
        endcase
    end

    assign last = (beat == final_beat);
endmodule

// File: rtl/bus16_lane_map.sv
// Lane mapper: for each byte of the current beat, finds its lane from the
// address parity and endian, and the datum byte it carries. Gives lane
// enables, lane write bytes and lane byte indices for read gathering.
// Assumes a two-byte beat always starts at an even address.
module bus16_lane_map
    import bus16_pkg::*;
(
    input  logic                big,
    input  logic                odd,
    input  acc_size_e           size,
    input  beat_t               plan,
    input  logic [DATUM_W-1:0]  wdata,
    output logic                hi_en,
    output logic                lo_en,
    output logic [LANE_W-1:0]   hi_byte,
    output logic [LANE_W-1:0]   lo_byte,
    output logic [IDX_W-1:0]    hi_idx,
    output logic [IDX_W-1:0]    lo_idx
);
    logic [IDX_W-1:0]                  top_idx;
    logic [BUS_BYTES-1:0]              s_use;
    logic [BUS_BYTES-1:0]              s_up;
    logic [BUS_BYTES-1:0][IDX_W-1:0]   s_idx;

    // Index of the most significant byte for this size.
    always_comb begin
        case (size)
            SZ_BYTE: top_idx = IDX_W'(0);
            SZ_WORD: top_idx = IDX_W'(1);
            default: top_idx = IDX_W'(DATUM_BYTES - 1);
        endcase
    end

    for (genvar j = 0; j < BUS_BYTES; j++) begin : g_slot
        logic [IDX_W-1:0] k;
        assign k = plan.offs + IDX_W'(j);
        if (j == 0) begin : g_first
            assign s_use[j] = 1'b1;
        end else begin : g_more
            assign s_use[j] = plan.two;
        end
        // Upper lane when big-endian and even address, or little-endian and odd.
        assign s_up[j]  = big ^ (odd ^ k[0]);
        assign s_idx[j] = big ? (top_idx - k) : k;
    end

    // Merge the slots onto the two lanes.
    always_comb begin
        hi_en  = 1'b0;
        lo_en  = 1'b0;
        hi_idx = '0;
        lo_idx = '0;
        for (int j = 0; j < BUS_BYTES; j++) begin
            if (s_use[j]) begin
                if (s_up[j]) begin
                    hi_en  = 1'b1;
                    hi_idx = s_idx[j];
                end else begin
                    lo_en  = 1'b1;
                    lo_idx = s_idx[j];
                end
            end
        end
    end

    assign hi_byte = hi_en ? wdata[{hi_idx, 3'b000} +: LANE_W] : '0;
    assign lo_byte = lo_en ? wdata[{lo_idx, 3'b000} +: LANE_W] : '0;
endmodule

// File: rtl/bus16_read_gather.sv
// Read gatherer: clears at request start and drops each returned lane byte
// into its datum position when a read beat completes.
// Assumes the two lanes never target the same position in one beat.
module bus16_read_gather
    import bus16_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                capture,
    input  logic                hi_en,
    input  logic                lo_en,
    input  logic [IDX_W-1:0]    hi_idx,
    input  logic [IDX_W-1:0]    lo_idx,
    input  logic [BUS_W-1:0]    rdata,
    output logic [DATUM_W-1:0]  result
);
    // Accumulate returned bytes; bytes never written stay zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (clear) begin
            result <= '0;
        end else if (capture) begin
            if (hi_en) result[{hi_idx, 3'b000} +: LANE_W] <= rdata[BUS_W-1 -: LANE_W];
            if (lo_en) result[{lo_idx, 3'b000} +: LANE_W] <= rdata[LANE_W-1:0];
        end
    end
endmodule

// File: rtl/bus16_splitter.sv
// Bus splitter top: takes one request while idle, holds it, and steps through
// its bus cycles, advancing on each bus_ready. Pulses done after the last one.
// Assumes the request fields are stable on the accepting edge only.
module bus16_splitter
    import bus16_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic                req_write,
    input  logic [DATUM_W-1:0]  req_wdata,
    input  logic                req_big_endian,
    output logic                done,
    output logic [DATUM_W-1:0]  rd_data,
    output logic                bus_cyc,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic                bus_hi_en,
    output logic                bus_lo_en,
    output logic                bus_rd,
    output logic                bus_wr,
    output logic [BUS_W-1:0]    bus_wdata,
    input  logic [BUS_W-1:0]    bus_rdata,
    input  logic                bus_ready
);
    logic                busy_q;
    logic [IDX_W-1:0]    beat_q;
    logic [ADDR_W-1:0]   addr_q;
    acc_size_e           size_q;
    logic                write_q;
    logic                big_q;
    logic [DATUM_W-1:0]  wdata_q;
    logic                done_q;

    logic                accept;
    logic                step;
    logic                finish;
    beat_t               plan;
    logic                last;
    logic                hi_en;
    logic                lo_en;
    logic [LANE_W-1:0]   hi_byte;
    logic [LANE_W-1:0]   lo_byte;
    logic [IDX_W-1:0]    hi_idx;
    logic [IDX_W-1:0]    lo_idx;

    assign accept = req_valid & ~busy_q;
    assign step   = busy_q & bus_ready;
    assign finish = step & last;

    // Hold the request for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            size_q  <= SZ_BYTE;
            write_q <= 1'b0;
            big_q   <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            size_q  <= acc_size_e'(req_size);
            write_q <= req_write;
            big_q   <= req_big_endian;
            wdata_q <= req_wdata;
        end
    end

    // Busy flag and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            beat_q <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            beat_q <= '0;
        end else if (finish) begin
            busy_q <= 1'b0;
            beat_q <= '0;
        end else if (step) begin
            beat_q <= beat_q + IDX_W'(1);
        end
    end

    // One-clock completion pulse after the final beat.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= finish;
    end

    bus16_cycle_plan u_plan (
        .size (size_q),
        .odd  (addr_q[0]),
        .beat (beat_q),
        .plan (plan),
        .last (last)
    );

    bus16_lane_map u_lanes (
        .big     (big_q),
        .odd     (addr_q[0]),
        .size    (size_q),
        .plan    (plan),
        .wdata   (wdata_q),
        .hi_en   (hi_en),
        .lo_en   (lo_en),
        .hi_byte (hi_byte),
        .lo_byte (lo_byte),
        .hi_idx  (hi_idx),
        .lo_idx  (lo_idx)
    );

    bus16_read_gather u_gather (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture (step & ~write_q),
        .hi_en   (hi_en),
        .lo_en   (lo_en),
        .hi_idx  (hi_idx),
        .lo_idx  (lo_idx),
        .rdata   (bus_rdata),
        .result  (rd_data)
    );

    assign req_ready = ~busy_q;
    assign done      = done_q;
    assign bus_cyc   = busy_q;
    assign bus_addr  = addr_q + ADDR_W'(plan.offs);
    assign bus_hi_en = busy_q & hi_en;
    assign bus_lo_en = busy_q & lo_en;
    assign bus_rd    = busy_q & ~write_q;
    assign bus_wr    = busy_q & write_q;
    assign bus_wdata = (busy_q & write_q) ? {hi_byte, lo_byte} : '0;
endmodule

// File: rtl/bus16_splitter_chk.sv
// Protocol checker for bus16_splitter, attached by bind.
module bus16_splitter_chk #(
    parameter int ADDR_W = 16,
    parameter int BUS_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              done,
    input logic              bus_cyc,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_hi_en,
    input logic              bus_lo_en,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              bus_ready
);
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cyc |-> !bus_hi_en && !bus_lo_en && !bus_rd && !bus_wr);

    assert_cycle_strobes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> (bus_hi_en || bus_lo_en) && (bus_rd != bus_wr));

    assert_wait_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc && !bus_ready |=> bus_cyc && $stable(bus_addr) && $stable(bus_hi_en)
                                  && $stable(bus_lo_en) && $stable(bus_wdata));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_cyc && bus_ready) && !bus_cyc);

    assert_busy_no_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> !req_ready);
endmodule

bind bus16_splitter bus16_splitter_chk #(.ADDR_W(ADDR_W), .BUS_W(bus16_pkg::BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .bus_cyc   (bus_cyc),
    .bus_addr  (bus_addr),
    .bus_hi_en (bus_hi_en),
    .bus_lo_en (bus_lo_en),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready)
);

// File: tb/bus16_splitter_tb.sv
module bus16_splitter_tb;
    localparam int AW = 16;
    localparam logic [AW-1:0] BASE = 16'h0044;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          req_write = 1'b0;
    logic [31:0]   req_wdata = '0;
    logic          req_big_endian = 1'b0;
    logic          done;
    logic [31:0]   rd_data;
    logic          bus_cyc;
    logic [AW-1:0] bus_addr;
    logic          bus_hi_en, bus_lo_en, bus_rd, bus_wr;
    logic [15:0]   bus_wdata;
    logic [15:0]   bus_rdata = '0;
    logic          bus_ready = 1'b0;

    bus16_splitter #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .req_big_endian(req_big_endian), .done(done),
        .rd_data(rd_data), .bus_cyc(bus_cyc), .bus_addr(bus_addr),
        .bus_hi_en(bus_hi_en), .bus_lo_en(bus_lo_en), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready)
    );

    int checks = 0;
    int fails  = 0;

    logic [7:0]    mem [16];
    int            ncyc;
    logic [AW-1:0] cyc_addr [4];
    int            cyc_lanes [4];
    bit            op_big, op_wr;
    int            stable_err, strobe_err;
    bit            fresh = 1'b1;
    int            wait_left = 0;
    int            seed = 0;
    logic [AW-1:0] cap_addr;
    logic          cap_hi, cap_lo;
    logic [15:0]   cap_wd;
    bit            done_prev = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] init_byte(input int a);
        return 8'((a * 37 + 11) & 8'hff);
    endfunction

    // External bus model: wait states from a rotating pattern, then one transfer.
    always @(negedge clk) begin
        if (!rst_n || !bus_cyc) begin
            bus_ready = 1'b0;
            fresh     = 1'b1;
        end else begin
            if (fresh) begin
                cap_addr  = bus_addr;
                cap_hi    = bus_hi_en;
                cap_lo    = bus_lo_en;
                cap_wd    = bus_wdata;
                fresh     = 1'b0;
                wait_left = seed % 3;
                seed++;
            end else if (bus_addr != cap_addr || bus_hi_en != cap_hi ||
                         bus_lo_en != cap_lo || bus_wdata != cap_wd) begin
                stable_err++;
            end
            if (wait_left == 0) begin
                logic [AW-1:0] wbase, ua, la;
                wbase = {bus_addr[AW-1:1], 1'b0};
                ua = wbase + (op_big ? 16'd0 : 16'd1);
                la = wbase + (op_big ? 16'd1 : 16'd0);
                if (bus_rd == op_wr || bus_wr != op_wr) strobe_err++;
                if (ncyc < 4) begin
                    cyc_addr[ncyc]  = bus_addr;
                    cyc_lanes[ncyc] = int'(bus_hi_en) + int'(bus_lo_en);
                end
                ncyc++;
                if (bus_wr) begin
                    if (bus_hi_en) mem[ua[3:0]] = bus_wdata[15:8];
                    if (bus_lo_en) mem[la[3:0]] = bus_wdata[7:0];
                end
                bus_rdata = {bus_hi_en ? mem[ua[3:0]] : 8'hEE,
                             bus_lo_en ? mem[la[3:0]] : 8'hEE};
                bus_ready = 1'b1;
                fresh     = 1'b1;
            end else begin
                bus_ready = 1'b0;
                wait_left--;
            end
        end
    end

    // R8: done must never stay high two clocks running.
    always @(negedge clk) begin
        if (rst_n && done && done_prev)
            check(1'b0, "R8", "done high two cycles", 1, 0);
        done_prev = done;
    end

    task automatic do_op(input int sz, input int off, input bit wr, input bit big,
                         input bit spurious);
        logic [AW-1:0] a;
        logic [31:0]   wd, exp_rd;
        int            nb, n;
        int            ko [3];
        int            kl [3];
        bit            got;
        string         ctag;

        a  = BASE + AW'(off);
        nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        wd = 32'h1A2B3C4D * (off + 1) + 32'(sz * 16'h0101) + (big ? 32'h5500_0000 : 32'h0);

        // Expected cycle plan from the size and alignment rules.
        if (sz == 0) begin
            n = 1; ko[0] = 0; kl[0] = 1;
            ctag = big ? "R1" : "R2";
        end else if (sz == 1) begin
            if (off % 2 == 0) begin n = 1; ko[0] = 0; kl[0] = 2; ctag = "R3"; end
            else begin n = 2; ko[0] = 0; kl[0] = 1; ko[1] = 1; kl[1] = 1; ctag = "R4"; end
        end else begin
            if (off % 2 == 0) begin n = 2; ko[0] = 0; kl[0] = 2; ko[1] = 2; kl[1] = 2; ctag = "R5"; end
            else begin
                n = 3; ko[0] = 0; kl[0] = 1; ko[1] = 1; kl[1] = 2; ko[2] = 3; kl[2] = 1;
                ctag = "R6";
            end
        end

        for (int i = 0; i < 16; i++) mem[i] = wr ? 8'h00 : init_byte(i);
        exp_rd = '0;
        for (int k = 0; k < nb; k++) begin
            int idx;
            idx = big ? (nb - 1 - k) : k;
            exp_rd[idx*8 +: 8] = init_byte((int'(a) + k) & 15);
        end

        ncyc = 0; stable_err = 0; strobe_err = 0;
        op_big = big; op_wr = wr;

        req_addr = a; req_size = 2'(sz); req_write = wr; req_wdata = wd;
        req_big_endian = big; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        got = 1'b0;
        if (spurious) begin
            // R11: a second request while busy must be ignored.
            req_addr  = a ^ 16'h0008;
            req_write = ~wr;
            check(req_ready == 1'b0, "R11", "req_ready while busy", req_ready, 0);
            @(negedge clk);
            req_valid = 1'b0;
            got = done;
        end else begin
            req_valid = 1'b0;
        end
        for (int t = 0; t < 200 && !got; t++) begin
            @(negedge clk);
            if (done) got = 1'b1;
        end
        check(got, "R8", "done seen", got, 1);

        check(ncyc == n, ctag, "bus cycle count", ncyc, n);
        for (int c = 0; c < n && c < ncyc && c < 4; c++) begin
            check(cyc_addr[c] == a + AW'(ko[c]), ctag, "cycle address",
                  cyc_addr[c], a + AW'(ko[c]));
            check(cyc_lanes[c] == kl[c], ctag, "cycle lane count", cyc_lanes[c], kl[c]);
        end
        check(stable_err == 0, "R10", "outputs moved during wait", stable_err, 0);
        check(strobe_err == 0, "R9", "read/write strobe", strobe_err, 0);

        if (wr) begin
            for (int k = 0; k < nb; k++) begin
                int idx;
                idx = big ? (nb - 1 - k) : k;
                check(mem[(int'(a) + k) & 15] == wd[idx*8 +: 8], "R7", "stored byte",
                      mem[(int'(a) + k) & 15], wd[idx*8 +: 8]);
            end
            check(mem[(int'(a) - 1) & 15] == 8'h00, "R9", "byte below untouched",
                  mem[(int'(a) - 1) & 15], 0);
            check(mem[(int'(a) + nb) & 15] == 8'h00, "R9", "byte above untouched",
                  mem[(int'(a) + nb) & 15], 0);
        end else begin
            check(rd_data == exp_rd, "R8", "read result", rd_data, exp_rd);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: idle state after reset.
        check(req_ready == 1'b1, "R12", "req_ready", req_ready, 1);
        check(bus_cyc == 1'b0, "R12", "bus_cyc", bus_cyc, 0);
        check(done == 1'b0, "R12", "done", done, 0);
        check(rd_data == 32'h0, "R12", "rd_data", rd_data, 0);
        check(!bus_hi_en && !bus_lo_en && !bus_rd && !bus_wr, "R9", "idle strobes",
              {bus_hi_en, bus_lo_en, bus_rd, bus_wr}, 0);

        for (int big = 0; big < 2; big++)
            for (int wr = 0; wr < 2; wr++)
                for (int sz = 0; sz < 3; sz++)
                    for (int off = 0; off < 4; off++)
                        do_op(sz, off, wr[0], big[0], (sz == 2 && off == 1));

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule